// File: doc/BRIEF.md
# Windowed Register File

This block is a register file that shows a processor a fixed set of 32 architectural registers while storing many more. Eight of them are globals that every procedure shares. The other 24 form a window of three groups: incoming arguments, private locals and outgoing arguments. A rotating window pointer picks which slice of a circular physical array is visible. On a procedure call the pointer moves by one window. The callee then sees the caller's outgoing registers as its own incoming registers, and gets an unused set of locals and outgoing registers. A return moves the pointer back, and the caller again finds its outgoing registers holding whatever the callee left in its incoming group.

The file has two combinational read ports and one write port, all addressed by 5-bit architectural numbers, plus call and return request inputs. With eight windows, at most seven can be resident at once, because the deepest window's outgoing group occupies the next window's incoming slots. An occupancy counter tracks how many are resident. A call made when all seven are resident raises a one-cycle overflow trap, and a return made with only one resident window raises a one-cycle underflow trap. In both cases the pointer stays where it is. Spilling windows to memory and filling them back is left to the trap handler outside the block.

Top module: `wrf_top`

## Requirements
- R1: After reset the window pointer is 0, both trap outputs are low, and every architectural register reads 0.
- R2: Register 0 always reads 0, and a write to it has no effect.
- R3: Registers 1 to 7 are globals. Their storage does not depend on the window pointer, so their values are the same before and after calls and returns.
- R4: Registers 8–15 are outs, 16–23 locals and 24–31 ins. After an accepted call, in register 24+k of the callee reads the value the caller left in out register 8+k.
- R5: A callee's locals are separate storage from the caller's locals. A callee that has never been written reads 0 in them, and writes to them leave the caller's locals unchanged after the return.
- R6: After an accepted return, out register 8+k of the caller reads the last value written to in register 24+k of the callee.
- R7: At most 7 windows are resident. A call made with 7 resident leaves the pointer unchanged, and overflowTrap is high in the one cycle after that clock edge.
- R8: A return made with only 1 resident window leaves the pointer unchanged, and underflowTrap is high in the one cycle after that clock edge.
- R9: An accepted call decrements winPtr modulo 8 (0 becomes 7). An accepted return increments it modulo 8 (7 becomes 0).
- R10: A write presented in the same cycle as an accepted call or return goes to the register selected by the window pointer as it was before that edge.
- R11: A call and a return requested in the same cycle are both ignored. The pointer does not move and neither trap is raised.
- R12: Reads are combinational from the current state. A read of the register being written in that cycle returns the old value, and the new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdAddrA | input | 5 | Architectural number for read port A |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 5 | Architectural number for read port B |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Architectural number written |
| wrData | input | 32 | Write data |
| callReq | input | 1 | Request to advance to a new window |
| retReq | input | 1 | Request to go back to the previous window |
| winPtr | output | 3 | Current window pointer |
| overflowTrap | output | 1 | One-cycle pulse when a call is refused |
| underflowTrap | output | 1 | One-cycle pulse when a return is refused |

## Verification
A register write and a window rotation can land on the same clock edge. In that case the architectural write address has to be resolved through the old pointer, not the new one. The bench writes a local register in the same cycle as a call, then reads the callee's copy of that register, which must still be 0, and the caller's copy after the return, which must hold the value. A call and a return requested together in a state where a lone return would underflow are also checked: the pointer must not move and no trap may appear.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  // Architectural register groups, taken from the top two address bits
  typedef enum logic [1:0] {
    GRP_GLB = 2'd0,
    GRP_OUT = 2'd1,
    GRP_LOC = 2'd2,
    GRP_IN  = 2'd3
  } regGroup_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic rotCall;   // accepted call: step pointer down
    logic rotRet;    // accepted return: step pointer up
  } wrfStrobe_t;

endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter int NUM_WIN = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 callReq,
  input  logic                 retReq,
  output wrf_pkg::wrfStrobe_t  strobe,
  output logic                 overflowTrap,
  output logic                 underflowTrap
);
  localparam int OCC_W   = $clog2(NUM_WIN) + 1;
  localparam int MAX_RES = NUM_WIN - 1;

  logic [OCC_W-1:0] occ;
  logic callOnly, retOnly, callRoom, retRoom;

  assign callOnly = callReq && !retReq;
  assign retOnly  = retReq && !callReq;
  assign callRoom = occ < OCC_W'(MAX_RES);
  assign retRoom  = occ > OCC_W'(1);

  always_comb begin
    strobe.rotCall = callOnly && callRoom;
    strobe.rotRet  = retOnly && retRoom;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occ           <= OCC_W'(1);
      overflowTrap  <= 1'b0;
      underflowTrap <= 1'b0;
    end else begin
      overflowTrap  <= callOnly && !callRoom;
      underflowTrap <= retOnly && !retRoom;
      if (strobe.rotCall)
        occ <= occ + 1'b1;
      else if (strobe.rotRet)
        occ <= occ - 1'b1;
    end
  end

  // R7
  occ_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (occ >= OCC_W'(1)) && (occ <= OCC_W'(MAX_RES)));

  // R7
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowTrap |-> ($past(callReq) && !$past(retReq)));

  // R8
  unf_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    underflowTrap |-> ($past(retReq) && !$past(callReq)));

endmodule

// File: rtl/wrf_data.sv
module wrf_data #(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wrf_pkg::wrfStrobe_t      strobe,
  input  logic [ADDR_W-1:0]        rdAddrA,
  output logic [DATA_W-1:0]        rdDataA,
  input  logic [ADDR_W-1:0]        rdAddrB,
  output logic [DATA_W-1:0]        rdDataB,
  input  logic                     wrEn,
  input  logic [ADDR_W-1:0]        wrAddr,
  input  logic [DATA_W-1:0]        wrData,
  output logic [$clog2(NUM_WIN)-1:0] cwpOut
);
  import wrf_pkg::*;

  localparam int KB      = ADDR_W - 2;
  localparam int GRP     = 1 << KB;
  localparam int WB      = $clog2(NUM_WIN);
  localparam int IDX_W   = WB + 1 + KB;
  localparam int WIN_ENT = NUM_WIN * 2 * GRP;

  logic [WB-1:0]     cwp;
  logic [DATA_W-1:0] glbMem [GRP];
  logic [DATA_W-1:0] winMem [WIN_ENT];

  // Windowed slot: owner window, half (0 local, 1 in), offset
  function automatic logic [IDX_W-1:0] mapIdx(input logic [ADDR_W-1:0] a,
                                               input logic [WB-1:0] w);
    logic [WB-1:0] owner;
    logic          half;
    case (regGroup_t'(a[ADDR_W-1 -: 2]))
      GRP_OUT: begin
        owner = (w == '0) ? WB'(NUM_WIN - 1) : w - 1'b1;
        half  = 1'b1;
      end
      GRP_LOC: begin
        owner = w;
        half  = 1'b0;
      end
      default: begin
        owner = w;
        half  = 1'b1;
      end
    endcase
    return {owner, half, a[KB-1:0]};
  endfunction

  function automatic logic isGlb(input logic [ADDR_W-1:0] a);
    return regGroup_t'(a[ADDR_W-1 -: 2]) == GRP_GLB;
  endfunction

  function automatic logic [DATA_W-1:0] readReg(input logic [ADDR_W-1:0] a);
    if (isGlb(a))
      return glbMem[a[KB-1:0]];
    return winMem[mapIdx(a, cwp)];
  endfunction

  assign rdDataA = readReg(rdAddrA);
  assign rdDataB = readReg(rdAddrB);
  assign cwpOut  = cwp;

  logic              wrGlb;
  logic [IDX_W-1:0]  wrIdx;
  assign wrGlb = isGlb(wrAddr);
  assign wrIdx = mapIdx(wrAddr, cwp);

  // Window pointer rotation
  always_ff @(posedge clk) begin
    if (!rstN)
      cwp <= '0;
    else if (strobe.rotCall)
      cwp <= (cwp == '0) ? WB'(NUM_WIN - 1) : cwp - 1'b1;
    else if (strobe.rotRet)
      cwp <= (cwp == WB'(NUM_WIN - 1)) ? '0 : cwp + 1'b1;
  end

  // Global storage; entry 0 is a hard zero
  for (genvar g = 0; g < GRP; g++) begin : gGlb
    if (g == 0) begin : gZero
      assign glbMem[g] = '0;
    end else begin : gReg
      always_ff @(posedge clk) begin
        if (!rstN)
          glbMem[g] <= '0;
        else if (wrEn && wrGlb && (wrAddr[KB-1:0] == KB'(g)))
          glbMem[g] <= wrData;
      end
    end
  end

  // Windowed storage
  for (genvar e = 0; e < WIN_ENT; e++) begin : gWin
    always_ff @(posedge clk) begin
      if (!rstN)
        winMem[e] <= '0;
      else if (wrEn && !wrGlb && (wrIdx == IDX_W'(e)))
        winMem[e] <= wrData;
    end
  end

  // R9 R4
  rot_call_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rotCall |=> (cwp == (($past(cwp) == '0) ? WB'(NUM_WIN - 1)
                                                   : WB'($past(cwp) - 1'b1))));

  // R9 R6
  rot_ret_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rotRet |=> (cwp == (($past(cwp) == WB'(NUM_WIN - 1)) ? '0
                                                   : WB'($past(cwp) + 1'b1))));

  // R7 R8 R11
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rotCall && !strobe.rotRet) |=> $stable(cwp));

endmodule

// File: rtl/wrf_top.sv
module wrf_top #(
  parameter int NUM_WIN = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 5,
  parameter int WB      = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              callReq,
  input  logic              retReq,
  output logic [WB-1:0]     winPtr,
  output logic              overflowTrap,
  output logic              underflowTrap
);
  wrf_pkg::wrfStrobe_t strobe;

  wrf_ctrl #(.NUM_WIN(NUM_WIN)) uCtrl (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .strobe(strobe), .overflowTrap(overflowTrap), .underflowTrap(underflowTrap)
  );

  wrf_data #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .cwpOut(winPtr)
  );

endmodule

// File: tb/tb_wrf_top.sv
module tb_wrf_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, callReq = 1'b0, retReq = 1'b0;
  logic [2:0]  winPtr;
  logic        overflowTrap, underflowTrap;

  int nChecks = 0;
  int nErr = 0;

  always #5 clk = ~clk;

  wrf_top dut (
    .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA),
    .rdAddrB(rdAddrB), .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .callReq(callReq), .retReq(retReq), .winPtr(winPtr),
    .overflowTrap(overflowTrap), .underflowTrap(underflowTrap)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    rdAddrA = a;
    rdAddrB = a;
    #1;
    d = rdDataA;
    if (rdDataB !== rdDataA) check("port B", rdDataB, rdDataA);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic req(input logic c, input logic r);
    callReq = c; retReq = r;
    @(negedge clk);
    callReq = 1'b0; retReq = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    check("R1 ptr", 32'(winPtr), 0);
    check("R1 ovf", 32'(overflowTrap), 0);
    check("R1 unf", 32'(underflowTrap), 0);
    for (int i = 0; i < 32; i += 5) begin
      rd(5'(i), d);
      check("R1 reg", d, 0);
    end
  endtask

  task automatic testZeroAndTiming();
    logic [31:0] d;
    wr(5'd0, 32'hDEAD_BEEF);
    rd(5'd0, d);
    check("R2 r0", d, 0);
    // R12: same-cycle read sees old value
    wrEn = 1'b1; wrAddr = 5'd9; wrData = 32'h1234;
    rd(5'd9, d);
    check("R12 old", d, 0);
    @(negedge clk);
    wrEn = 1'b0;
    rd(5'd9, d);
    check("R12 new", d, 32'h1234);
  endtask

  task automatic testCallReturn();
    logic [31:0] d;
    for (int k = 0; k < 8; k++) begin
      wr(5'(8 + k), 32'h100 + k);
      wr(5'(16 + k), 32'h200 + k);
      if (k > 0) wr(5'(k), 32'h300 + k);
    end
    req(1'b1, 1'b0);
    check("R9 wrap down", 32'(winPtr), 7);
    for (int k = 0; k < 8; k++) begin
      rd(5'(24 + k), d);
      check("R4 in=out", d, 32'h100 + k);
    end
    rd(5'd3, d);
    check("R3 global in callee", d, 32'h303);
    rd(5'd17, d);
    check("R5 fresh local", d, 0);
    wr(5'd16, 32'hAAA);
    wr(5'd24, 32'h555);
    wr(5'd7, 32'h777);
    req(1'b0, 1'b1);
    check("R9 wrap up", 32'(winPtr), 0);
    rd(5'd16, d);
    check("R5 caller local", d, 32'h200);
    rd(5'd8, d);
    check("R6 out returned", d, 32'h555);
    rd(5'd9, d);
    check("R6 out intact", d, 32'h101);
    rd(5'd7, d);
    check("R3 global after", d, 32'h777);
  endtask

  task automatic testTraps();
    logic [2:0] expPtr = 3'd0;
    for (int i = 0; i < 6; i++) begin
      req(1'b1, 1'b0);
      expPtr = expPtr - 3'd1;
      check("R9 call ptr", 32'(winPtr), 32'(expPtr));
      check("R7 no trap", 32'(overflowTrap), 0);
    end
    req(1'b1, 1'b0);
    check("R7 ovf trap", 32'(overflowTrap), 1);
    check("R7 ptr held", 32'(winPtr), 32'(expPtr));
    @(negedge clk);
    check("R7 one cycle", 32'(overflowTrap), 0);
    for (int i = 0; i < 6; i++) begin
      req(1'b0, 1'b1);
      expPtr = expPtr + 3'd1;
      check("R9 ret ptr", 32'(winPtr), 32'(expPtr));
      check("R8 no trap", 32'(underflowTrap), 0);
    end
    req(1'b0, 1'b1);
    check("R8 unf trap", 32'(underflowTrap), 1);
    check("R8 ptr held", 32'(winPtr), 0);
    @(negedge clk);
    check("R8 one cycle", 32'(underflowTrap), 0);
  endtask

  task automatic testSameCycle();
    logic [31:0] d;
    // R10: write with call uses pre-call window
    wrEn = 1'b1; wrAddr = 5'd18; wrData = 32'h77;
    callReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; callReq = 1'b0;
    check("R10 ptr", 32'(winPtr), 7);
    rd(5'd18, d);
    check("R10 callee local", d, 0);
    req(1'b0, 1'b1);
    rd(5'd18, d);
    check("R10 caller local", d, 32'h77);
    // R11: call with return, at one resident window
    req(1'b1, 1'b1);
    check("R11 ptr", 32'(winPtr), 0);
    check("R11 unf", 32'(underflowTrap), 0);
    check("R11 ovf", 32'(overflowTrap), 0);
  endtask

  initial begin
    #2000000;
    nErr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testZeroAndTiming();
    testCallReturn();
    testTraps();
    testSameCycle();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

endmodule